// File: doc/BRIEF.md
# Fly-By DMA Channel Sequencer

This block moves words between an I/O device and memory on behalf of the processor, without the data ever passing through it. It has four channels. Software sets up each one with a transfer direction, a first memory address and a word count. A device asks for service on its request line. The sequencer then asks the processor for the bus and waits until the processor grants it. Next it acknowledges the device and runs the whole block of words. For each word it drives the memory address together with a matched pair of read and write strobes. When the count runs out it gives the bus back and raises a completion interrupt.

Only one channel owns the bus at a time. The choice is made by a fixed-priority arbiter that works only while the bus is free. Each channel also has a sticky completion flag, which software collects and clears with a single read strobe.

Top module: `flyby_dma`

## Requirements
- R1: After a synchronous reset the following outputs are all low: `hrq`, every bit of `dack`, `memr`, `memw`, `ior`, `iow`, `irq` and `tc_rdata`.
- R2: Suppose the sequencer is idle and a channel has a nonzero count and a high request. Then `hrq` rises on the next clock. `dack` stays zero until `hlda` has been sampled high.
- R3: The cycle after `hlda` is sampled high, `dack` is one-hot on the granted channel. It stays so for the whole block. No strobe is ever active without both `hrq` and `hlda`.
- R4: Direction 0 is memory to device. For each word, `addr_out` holds the address while `memr` rises. One cycle later `iow` rises. Both fall together after one cycle of overlap.
- R5: Direction 1 is device to memory. It uses the same pattern as R4, with `ior` in place of `memr` and `memw` in place of `iow`.
- R6: A channel programmed with count N and address A performs exactly N writes, at addresses A, A+1, … in that order. The address wraps modulo 2^AW.
- R7: After the last word, `hrq` and the granted `dack` bit fall on the same clock edge. On that edge `irq` is raised for exactly one cycle.
- R8: If several armed requests are present when the bus is free, the lowest channel number wins. A request that arrives during a block does not interrupt that block. It is served afterwards.
- R9: A channel whose count is zero ignores its request: `hrq` stays low.
- R10: Completing a block sets that channel's bit in the status flags. Bit i belongs to channel i. A one-cycle `tc_rd` pulse copies the flags to `tc_rdata` on the next clock and clears them. A read that immediately follows returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write channel setup |
| cfg_ch | input | 2 | Channel being set up |
| cfg_dir | input | 1 | 0 memory→device, 1 device→memory |
| cfg_addr | input | AW (16) | First memory address |
| cfg_cnt | input | CW (16) | Number of words |
| dreq | input | NCH (4) | Device service requests |
| hlda | input | 1 | Bus granted by processor |
| tc_rd | input | 1 | Read-and-clear of completion flags |
| hrq | output | 1 | Bus request to processor |
| dack | output | NCH (4) | Device acknowledge, one-hot |
| addr_out | output | AW (16) | Memory address |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | Device read strobe |
| iow | output | 1 | Device write strobe |
| irq | output | 1 | Completion interrupt pulse |
| tc_rdata | output | NCH (4) | Completion flags returned by a read |

## Verification
The first pattern is a single channel in each direction. It separates the strobe pairing of the two directions, and with a start address near the top of the space it also shows the address wrap. The second pattern raises two requests in the same cycle, which exposes the priority order. The third raises a high-priority request during a lower channel's block, which tells fixed priority apart from preemption. A request on an unprogrammed channel and back-to-back flag reads cover the zero-count and read-clear cases.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_SETUP, S_RD, S_WR, S_FIN
  } seq_state_t;
  localparam logic DIR_MEM2IO = 1'b0;
  localparam logic DIR_IO2MEM = 1'b1;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/dma_chregs.sv
module dma_chregs #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_dir,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic           upd,
  input  logic [CHW-1:0] sel_ch,
  output logic [NCH-1:0] armed,
  output logic [AW-1:0]  sel_addr,
  output logic [CW-1:0]  sel_cnt,
  output logic           sel_dir
);
  logic [AW-1:0] addr_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];
  logic          dir_q  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
        dir_q[g]  <= 1'b0;
      end else if (upd && sel_ch == CHW'(g)) begin
        addr_q[g] <= addr_q[g] + AW'(1);
        cnt_q[g]  <= cnt_q[g] - CW'(1);
      end else if (cfg_we && cfg_ch == CHW'(g)) begin
        addr_q[g] <= cfg_addr;
        cnt_q[g]  <= cfg_cnt;
        dir_q[g]  <= cfg_dir;
      end
    end
    assign armed[g] = (cnt_q[g] != '0);
  end

  assign sel_addr = addr_q[sel_ch];
  assign sel_cnt  = cnt_q[sel_ch];
  assign sel_dir  = dir_q[sel_ch];
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_any,
  input  logic [CHW-1:0] req_idx,
  input  logic           hlda,
  input  logic [AW-1:0]  ch_addr,
  input  logic [CW-1:0]  ch_cnt,
  input  logic           ch_dir,
  output logic [CHW-1:0] cur_ch,
  output logic           upd,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic [AW-1:0]  addr_out,
  output logic           memr,
  output logic           memw,
  output logic           ior,
  output logic           iow,
  output logic           irq
);
  seq_state_t state;

  assign upd = (state == S_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur_ch   <= '0;
      hrq      <= 1'b0;
      dack     <= '0;
      addr_out <= '0;
      memr     <= 1'b0;
      memw     <= 1'b0;
      ior      <= 1'b0;
      iow      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          irq <= 1'b0;
          if (req_any) begin
            cur_ch <= req_idx;
            hrq    <= 1'b1;
            state  <= S_REQ;
          end
        end
        S_REQ: begin
          if (hlda) begin
            dack  <= {{(NCH-1){1'b0}}, 1'b1} << cur_ch;
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          addr_out <= ch_addr;
          if (ch_dir == DIR_MEM2IO) memr <= 1'b1;
          else                      ior  <= 1'b1;
          state <= S_RD;
        end
        S_RD: begin
          if (ch_dir == DIR_MEM2IO) iow  <= 1'b1;
          else                      memw <= 1'b1;
          state <= S_WR;
        end
        S_WR: begin
          memr <= 1'b0;
          memw <= 1'b0;
          ior  <= 1'b0;
          iow  <= 1'b0;
          state <= (ch_cnt == CW'(1)) ? S_FIN : S_SETUP;
        end
        S_FIN: begin
          hrq   <= 1'b0;
          dack  <= '0;
          irq   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_dir,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           tc_rd,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic [AW-1:0]  addr_out,
  output logic           memr,
  output logic           memw,
  output logic           ior,
  output logic           iow,
  output logic           irq,
  output logic [NCH-1:0] tc_rdata
);
  logic [NCH-1:0] armed;
  logic           req_any;
  logic [CHW-1:0] req_idx;
  logic [CHW-1:0] cur_ch;
  logic           upd;
  logic [AW-1:0]  sel_addr;
  logic [CW-1:0]  sel_cnt;
  logic           sel_dir;
  logic [NCH-1:0] tc_flags;
  logic [NCH-1:0] tc_set;

  dma_arb #(.NCH(NCH)) u_arb (
    .req (dreq & armed),
    .any (req_any),
    .idx (req_idx)
  );

  dma_chregs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
    .clk, .rst, .cfg_we, .cfg_ch, .cfg_dir, .cfg_addr, .cfg_cnt,
    .upd, .sel_ch(cur_ch), .armed, .sel_addr, .sel_cnt, .sel_dir
  );

  dma_seq #(.NCH(NCH), .AW(AW), .CW(CW)) u_seq (
    .clk, .rst, .req_any, .req_idx, .hlda,
    .ch_addr(sel_addr), .ch_cnt(sel_cnt), .ch_dir(sel_dir),
    .cur_ch, .upd, .hrq, .dack, .addr_out,
    .memr, .memw, .ior, .iow, .irq
  );

  // a finishing block is flagged when its final word is written
  assign tc_set = (upd && sel_cnt == CW'(1)) ? ({{(NCH-1){1'b0}}, 1'b1} << cur_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_flags <= '0;
      tc_rdata <= '0;
    end else if (tc_rd) begin
      tc_rdata <= tc_flags;
      tc_flags <= tc_set;
    end else begin
      tc_flags <= tc_flags | tc_set;
    end
  end
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hrq,
  input logic           hlda,
  input logic [NCH-1:0] dack,
  input logic           memr,
  input logic           memw,
  input logic           ior,
  input logic           iow,
  input logic           irq
);
  a_r3_dack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));
  a_r2_dack_needs_hrq: assert property (@(posedge clk) disable iff (rst)
    (dack != '0) |-> hrq);
  a_r3_strobe_needs_bus: assert property (@(posedge clk) disable iff (rst)
    (memr || memw || ior || iow) |-> (hrq && hlda && dack != '0));
  a_r4_pair_mem2io: assert property (@(posedge clk) disable iff (rst)
    (memr || iow) |-> !(ior || memw));
  a_r4_iow_after_memr: assert property (@(posedge clk) disable iff (rst)
    iow |-> memr);
  a_r5_memw_after_ior: assert property (@(posedge clk) disable iff (rst)
    memw |-> ior);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r7_irq_bus_free: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!hrq && dack == '0));
endmodule

bind flyby_dma dma_chk #(.NCH(NCH)) u_chk (
  .clk, .rst, .hrq, .hlda, .dack, .memr, .memw, .ior, .iow, .irq
);

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic cfg_dir = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [NCH-1:0] dreq = '0;
  logic hlda = 1'b0;
  logic tc_rd = 1'b0;
  logic hrq, memr, memw, ior, iow, irq;
  logic [NCH-1:0] dack, tc_rdata;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  int hold_delay = 3;
  logic [18:0] expq[$];

  always #5 clk = ~clk;

  flyby_dma #(.NCH(NCH), .AW(AW), .CW(CW)) u_dut (
    .clk, .rst, .cfg_we, .cfg_ch, .cfg_dir, .cfg_addr, .cfg_cnt,
    .dreq, .hlda, .tc_rd, .hrq, .dack, .addr_out,
    .memr, .memw, .ior, .iow, .irq, .tc_rdata
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // processor model: grants the bus a few cycles after the request
  int hcnt = 0;
  always @(negedge clk) begin
    if (!hrq) begin hcnt <= 0; hlda <= 1'b0; end
    else begin
      hcnt <= hcnt + 1;
      if (hcnt + 1 >= hold_delay) hlda <= 1'b1;
    end
  end

  // monitor: one scoreboard item per write strobe
  logic rd_prev = 1'b0;
  always @(negedge clk) begin
    logic wr, rd, dir;
    logic [1:0] ch;
    logic [18:0] e;
    wr = memw | iow;
    rd = memr | ior;
    dir = memw | ior;
    ch = 2'd0;
    for (int i = 0; i < NCH; i++) if (dack[i]) ch = 2'(i);
    if (irq) begin
      irq_seen++;
      check(!hrq && dack == '0, "R7 bus released at irq", {hrq, dack}, 0);
    end
    if (wr && !rst) begin
      check(rd_prev && rd, "R4/R5 read strobe leads write", {rd_prev, rd}, 2'b11);
      if (expq.size() == 0) check(1'b0, "R6 unexpected word", {ch, dir, addr_out}, 0);
      else begin
        e = expq.pop_front();
        check({ch, dir, addr_out} == e, "R6/R8 word ch,dir,addr", {ch, dir, addr_out}, e);
        check(dir ? (ior && memw && !memr && !iow) : (memr && iow && !ior && !memw),
              "R4/R5 strobe pair for direction", {memr, memw, ior, iow}, dir ? 4'b0110 : 4'b1001);
      end
    end
    rd_prev = rd;
  end

  task automatic prog(input int ch, input bit dir, input int addr, input int cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_dir = dir;
    cfg_addr = AW'(addr); cfg_cnt = CW'(cnt);
    @(negedge clk);
    cfg_we = 1'b0;
    for (int i = 0; i < cnt; i++) expq.push_back({2'(ch), dir, AW'(addr + i)});
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    check(irq, req, {31'd0, irq}, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({hrq, dack, memr, memw, ior, iow, irq, tc_rdata} == '0, "R1 reset outputs",
          {hrq, dack, memr, memw, ior, iow, irq, tc_rdata}, 0);

    // R9 unprogrammed channel ignored
    dreq = 4'b1000;
    repeat (8) @(negedge clk);
    check(!hrq, "R9 zero count keeps hrq low", {31'd0, hrq}, 0);
    dreq = '0;

    // R2/R3/R4 single channel memory to device
    prog(0, 1'b0, 'h100, 3);
    dreq = 4'b0001;
    @(negedge clk);
    check(hrq, "R2 hrq rises after request", {31'd0, hrq}, 1);
    check(dack == '0, "R2 no dack before hlda", dack, 0);
    while (!hlda) @(negedge clk);
    @(negedge clk);
    check(dack == 4'b0001, "R3 dack one-hot after hlda", dack, 4'b0001);
    wait_irq("R7 irq after ch0 block");
    dreq = '0;
    check(expq.size() == 0, "R6 ch0 exact count", expq.size(), 0);

    // R5/R6 device to memory with address wrap
    prog(2, 1'b1, 'hFFFE, 4);
    dreq = 4'b0100;
    wait_irq("R7 irq after ch2 block");
    dreq = '0;
    check(expq.size() == 0, "R6 ch2 wrap exact count", expq.size(), 0);

    // R10 flag read and clear
    @(negedge clk); tc_rd = 1'b1; @(negedge clk); tc_rd = 1'b0;
    check(tc_rdata == 4'b0101, "R10 flags ch0 ch2", tc_rdata, 4'b0101);
    @(negedge clk); tc_rd = 1'b1; @(negedge clk); tc_rd = 1'b0;
    check(tc_rdata == 4'b0000, "R10 second read zero", tc_rdata, 0);

    // R8 simultaneous requests: ch1 before ch3
    hold_delay = 1;
    prog(1, 1'b0, 'h200, 2);
    prog(3, 1'b1, 'h300, 2);
    dreq = 4'b1010;
    wait_irq("R8 first block irq");
    wait_irq("R8 second block irq");
    dreq = '0;
    check(expq.size() == 0, "R8 both blocks done", expq.size(), 0);

    // R8 no preemption: ch2 running, ch0 arrives late
    hold_delay = 2;
    prog(2, 1'b0, 'h400, 3);
    prog(0, 1'b1, 'h500, 1);
    dreq = 4'b0100;
    while (dack == '0) @(negedge clk);
    dreq = 4'b0101;
    @(negedge clk);
    check(dack == 4'b0100, "R8 running block keeps bus", dack, 4'b0100);
    wait_irq("R8 ch2 irq");
    wait_irq("R8 ch0 irq");
    dreq = '0;
    check(expq.size() == 0, "R8 late request served after", expq.size(), 0);
    check(irq_seen == 6, "R7 one irq per block", irq_seen, 6);

    @(negedge clk); tc_rd = 1'b1; @(negedge clk); tc_rd = 1'b0;
    check(tc_rdata == 4'b1111, "R10 flags all channels", tc_rdata, 4'b1111);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule